// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer fetch engine and a display pipeline. It accepts 32-bit words read from memory and produces one pixel per output handshake. A 3-bit depth code sets how wide each pixel is. Pixels of 1, 2, 4 or 8 bits leave as palette indices. Wider pixels leave as an 8-bit-per-channel red/green/blue triple. Run-time controls choose big-endian byte order, big-endian pixel order inside a byte, and which end of a colour word carries blue. A 2-bit board-level select can also reinterpret 16-bit pixels.

A second, purely combinational path converts a pixels-per-line count into the number of source bytes that one line occupies at the current depth, for use by the fetch engine. A one-cycle start-of-line pulse drops whatever is left of the current word, so every line starts on a word boundary. The parameter `EXTENDED` chooses between two variants. The basic variant decodes the board select for depth code 4. The extended variant has fixed 5551 and 565 codes and ignores the select.

Top module: `fbu_pixel_unpack`

## Requirements
- R1: Depth codes 0, 1, 2 and 3 give 1-, 2-, 4- and 8-bit pixels. These are emitted zero-extended on `out_index` with `out_is_index`=1 and all colour outputs 0. Codes 4 to 7 (16, 32, 16 as 565, 12 bits) are emitted as colour with `out_is_index`=0 and `out_index`=0.
- R2: `line_bytes` equals `line_pixels` divided by 8, 4 or 2 for codes 0, 1, 2, equals it for code 3, doubles it for codes 4, 6 and 7, and quadruples it for code 5.
- R3: With both order controls clear, pixel k of a word occupies bits starting at k·w, where w is the pixel width. A 12-bit pixel sits in the low 12 bits of a 16-bit slot, so w=16 for code 7. A word holds 32/w pixels, emitted in increasing k.
- R4: With `be_bytes`=1, pixel k starts at bit 32−(k+1)·w, so pixel 0 comes from the most significant end of the word. `be_pixels` is then ignored.
- R5: With `be_pixels`=1 and `be_bytes`=0, bytes are taken from the least significant byte upward, and pixels narrower than 8 bits are taken from the most significant end of each byte. Pixels of 8 bits or more are unaffected.
- R6: Colour fields, from least significant upward: 5551 uses 5,5,5 bits (bit 15 ignored); 565 uses 5,6,5 bits; 12-bit uses 4,4,4 bits; 32-bit uses 8,8,8 bits (bits 31:24 ignored). Green is always the middle field. With `bgr_order`=1, blue is the lowest field and red the highest. With `bgr_order`=0, the two are swapped.
- R7: Each 5-, 6- or 4-bit field is widened to 8 bits by a left shift with zero fill.
- R8: Basic variant, code 4: `fmt_mux`=1 selects 5551. `fmt_mux`=3 selects 565 with blue in the lowest field regardless of `bgr_order`. `fmt_mux`=0 or 2 selects 565 honouring `bgr_order`. Code 6 is 565 honouring `bgr_order`.
- R9: Extended variant: code 4 is always 5551 and code 6 is always 565, both honouring `bgr_order`, and `fmt_mux` has no effect.
- R10: A word accepted at a clock edge makes `out_valid` high after that edge. Each output handshake advances one pixel. While `out_ready` is low the output is held steady. `in_ready` is high only when no word is held, or when the last pixel of the held word is being accepted in the same cycle.
- R11: While `sol` is high, `in_ready` is low. After the edge, `out_valid` is low and the next accepted word starts at pixel 0.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sol | input | 1 | Start-of-line pulse; flushes the held word |
| depth | input | 3 | Pixel depth code |
| bgr_order | input | 1 | 1 = blue in the lowest colour field |
| be_bytes | input | 1 | Big-endian byte order |
| be_pixels | input | 1 | Big-endian pixel order inside a byte |
| fmt_mux | input | 2 | Board select for 16-bit interpretation (basic variant) |
| line_pixels | input | PIX_W | Pixels per line |
| line_bytes | output | PIX_W+2 | Source bytes per line |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_word | input | 32 | Framebuffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel consumer ready |
| out_is_index | output | 1 | 1 = pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_red | output | 8 | Red channel |
| out_green | output | 8 | Green channel |
| out_blue | output | 8 | Blue channel |

## Verification
Only one register stage holds a word, so a word accepted at edge n shows up as a valid pixel right after edge n. From then on, every pixel field is a combinational function of that held word, the pixel position and the live controls. `line_bytes` and `in_ready` follow their inputs within the same cycle. The bench changes every input on the falling edge and samples 1 ns later, so each check sees the settled result of the edge just past. Two instances, one per variant, share all stimulus, and each pixel is compared on both against a model built from the bit-offset formulas in the requirements.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

   typedef enum logic [2:0] {
      DEP_1    = 3'd0,
      DEP_2    = 3'd1,
      DEP_4    = 3'd2,
      DEP_8    = 3'd3,
      DEP_16   = 3'd4,
      DEP_32   = 3'd5,
      DEP_565  = 3'd6,
      DEP_12   = 3'd7
   } depth_e;

   typedef enum logic [1:0] {
      CF_5551 = 2'd0,
      CF_565  = 2'd1,
      CF_444  = 2'd2,
      CF_888  = 2'd3
   } cfmt_e;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned POS_W  = 5;

   // log2 of the storage slot width of one pixel
   function automatic logic [2:0] slot_log2(input depth_e d);
      case (d)
         DEP_1:   return 3'd0;
         DEP_2:   return 3'd1;
         DEP_4:   return 3'd2;
         DEP_8:   return 3'd3;
         DEP_32:  return 3'd5;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/fbu_line_bytes.sv
module fbu_line_bytes
   import fbu_pkg::*;
#(
   parameter int unsigned PIX_W = 12
) (
   input  depth_e           depth_i,
   input  logic [PIX_W-1:0] pixels_i,
   output logic [PIX_W+1:0] bytes_o
);
   localparam int unsigned OUT_W = PIX_W + 2;

   logic [OUT_W-1:0] px_ext;
   assign px_ext = OUT_W'(pixels_i);

   always_comb begin
      case (depth_i)
         DEP_1:   bytes_o = px_ext >> 3;
         DEP_2:   bytes_o = px_ext >> 2;
         DEP_4:   bytes_o = px_ext >> 1;
         DEP_8:   bytes_o = px_ext;
         DEP_32:  bytes_o = px_ext << 2;
         default: bytes_o = px_ext << 1;
      endcase
   end
endmodule

// File: rtl/fbu_fmt_sel.sv
module fbu_fmt_sel
   import fbu_pkg::*;
#(
   parameter bit EXTENDED = 1'b0
) (
   input  depth_e     depth_i,
   input  logic [1:0] mux_i,
   input  logic       bgr_i,
   output cfmt_e      fmt_o,
   output logic       blue_low_o
);
   generate
      if (EXTENDED) begin : g_ext
         logic unused_mux;
         assign unused_mux = ^mux_i;
         always_comb begin
            blue_low_o = bgr_i;
            case (depth_i)
               DEP_32:  fmt_o = CF_888;
               DEP_12:  fmt_o = CF_444;
               DEP_565: fmt_o = CF_565;
               default: fmt_o = CF_5551;
            endcase
         end
      end else begin : g_basic
         always_comb begin
            blue_low_o = bgr_i;
            case (depth_i)
               DEP_32:  fmt_o = CF_888;
               DEP_12:  fmt_o = CF_444;
               DEP_565: fmt_o = CF_565;
               DEP_16: begin
                  case (mux_i)
                     2'd1:    fmt_o = CF_5551;
                     2'd3: begin
                        fmt_o      = CF_565;
                        blue_low_o = 1'b1;
                     end
                     default: fmt_o = CF_565;
                  endcase
               end
               default: fmt_o = CF_5551;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/fbu_word_buf.sv
module fbu_word_buf
   import fbu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sol_i,
   input  logic              in_valid_i,
   input  logic [WORD_W-1:0] in_word_i,
   output logic              in_ready_o,
   input  logic              out_ready_i,
   input  logic [POS_W-1:0]  last_pos_i,
   output logic              full_o,
   output logic [WORD_W-1:0] word_o,
   output logic [POS_W-1:0]  pos_o
);
   logic at_last, take_in, take_out;

   assign at_last    = (pos_o >= last_pos_i);
   assign in_ready_o = !sol_i && (!full_o || (out_ready_i && at_last));
   assign take_in    = in_valid_i && in_ready_o;
   assign take_out   = full_o && out_ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         pos_o  <= '0;
         word_o <= '0;
      end else if (sol_i) begin
         full_o <= 1'b0;
         pos_o  <= '0;
      end else if (take_in) begin
         full_o <= 1'b1;
         pos_o  <= '0;
         word_o <= in_word_i;
      end else if (take_out && at_last) begin
         full_o <= 1'b0;
         pos_o  <= '0;
      end else if (take_out) begin
         pos_o  <= pos_o + 1'b1;
      end
   end

   // R10: a stalled pixel stays put
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && !out_ready_i && !sol_i) |=> (full_o && $stable(pos_o) && $stable(word_o)));

   // R10: an accepted word starts at pixel 0
   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ready_o) |=> (full_o && pos_o == '0));

   // R10: a consumed non-final pixel steps the position by one
   p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && out_ready_i && !at_last && !sol_i) |=> (pos_o == $past(pos_o) + 1'b1));

   // R11: start of line flushes the held word
   p_sol_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sol_i |=> (!full_o && pos_o == '0));
endmodule

// File: rtl/fbu_pix_extract.sv
module fbu_pix_extract
   import fbu_pkg::*;
(
   input  logic [WORD_W-1:0] word_i,
   input  logic [POS_W-1:0]  pos_i,
   input  depth_e            depth_i,
   input  logic              be_bytes_i,
   input  logic              be_pixels_i,
   input  cfmt_e             fmt_i,
   input  logic              blue_low_i,
   output logic [POS_W-1:0]  last_pos_o,
   output logic              is_index_o,
   output logic [7:0]        index_o,
   output logic [7:0]        red_o,
   output logic [7:0]        green_o,
   output logic [7:0]        blue_o
);
   logic [2:0]       lw;
   logic [POS_W-1:0] off_base, hi_mask, off;
   logic [23:0]      raw;
   logic [7:0]       idx_mask;
   logic [7:0]       f_lo, f_mid, f_hi;

   assign lw         = slot_log2(depth_i);
   assign last_pos_o = POS_W'((6'd32 >> lw) - 6'd1);
   assign off_base   = POS_W'(pos_i << lw);
   assign hi_mask    = POS_W'(5'h1F << lw);

   // Reverse order by flipping the offset bits above the slot width
   always_comb begin
      if (be_bytes_i)
         off = off_base ^ hi_mask;
      else if (be_pixels_i)
         off = off_base ^ (hi_mask & 5'h07);
      else
         off = off_base;
   end

   assign raw        = 24'(word_i >> off);
   assign is_index_o = (lw <= 3'd3);
   assign idx_mask   = 8'hFF >> (4'd8 - (4'd1 << lw));

   always_comb begin
      case (fmt_i)
         CF_5551: begin
            f_lo  = {raw[4:0],   3'b000};
            f_mid = {raw[9:5],   3'b000};
            f_hi  = {raw[14:10], 3'b000};
         end
         CF_565: begin
            f_lo  = {raw[4:0],   3'b000};
            f_mid = {raw[10:5],  2'b00};
            f_hi  = {raw[15:11], 3'b000};
         end
         CF_444: begin
            f_lo  = {raw[3:0],   4'b0000};
            f_mid = {raw[7:4],   4'b0000};
            f_hi  = {raw[11:8],  4'b0000};
         end
         default: begin
            f_lo  = raw[7:0];
            f_mid = raw[15:8];
            f_hi  = raw[23:16];
         end
      endcase
   end

   always_comb begin
      if (is_index_o) begin
         index_o = raw[7:0] & idx_mask;
         red_o   = '0;
         green_o = '0;
         blue_o  = '0;
      end else begin
         index_o = '0;
         green_o = f_mid;
         red_o   = blue_low_i ? f_hi : f_lo;
         blue_o  = blue_low_i ? f_lo : f_hi;
      end
   end
endmodule

// File: rtl/fbu_pixel_unpack.sv
module fbu_pixel_unpack
   import fbu_pkg::*;
#(
   parameter bit          EXTENDED = 1'b0,
   parameter int unsigned PIX_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sol,
   input  logic [2:0]       depth,
   input  logic             bgr_order,
   input  logic             be_bytes,
   input  logic             be_pixels,
   input  logic [1:0]       fmt_mux,
   input  logic [PIX_W-1:0] line_pixels,
   output logic [PIX_W+1:0] line_bytes,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [31:0]      in_word,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_is_index,
   output logic [7:0]       out_index,
   output logic [7:0]       out_red,
   output logic [7:0]       out_green,
   output logic [7:0]       out_blue
);
   generate
      if (PIX_W < 4 || PIX_W > 24) begin : g_bad_pix_w
         $error("fbu_pixel_unpack: PIX_W must lie in 4..24");
      end
   endgenerate

   depth_e           dep;
   cfmt_e            fmt;
   logic             blue_low;
   logic [POS_W-1:0] last_pos, pos;
   logic [WORD_W-1:0] word;

   assign dep = depth_e'(depth);

   fbu_line_bytes #(.PIX_W(PIX_W)) u_lbytes (
      .depth_i  (dep),
      .pixels_i (line_pixels),
      .bytes_o  (line_bytes)
   );

   fbu_fmt_sel #(.EXTENDED(EXTENDED)) u_fmt (
      .depth_i    (dep),
      .mux_i      (fmt_mux),
      .bgr_i      (bgr_order),
      .fmt_o      (fmt),
      .blue_low_o (blue_low)
   );

   fbu_word_buf u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .sol_i       (sol),
      .in_valid_i  (in_valid),
      .in_word_i   (in_word),
      .in_ready_o  (in_ready),
      .out_ready_i (out_ready),
      .last_pos_i  (last_pos),
      .full_o      (out_valid),
      .word_o      (word),
      .pos_o       (pos)
   );

   fbu_pix_extract u_ext (
      .word_i      (word),
      .pos_i       (pos),
      .depth_i     (dep),
      .be_bytes_i  (be_bytes),
      .be_pixels_i (be_pixels),
      .fmt_i       (fmt),
      .blue_low_i  (blue_low),
      .last_pos_o  (last_pos),
      .is_index_o  (out_is_index),
      .index_o     (out_index),
      .red_o       (out_red),
      .green_o     (out_green),
      .blue_o      (out_blue)
   );

   // R1: an index pixel carries no colour
   p_index_no_rgb_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_is_index) |-> ({out_red, out_green, out_blue} == 24'h0));

   // R1: a colour pixel carries no index
   p_rgb_no_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_is_index) |-> (out_index == 8'h0));

   // R11: nothing is valid right after a start-of-line pulse
   p_sol_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sol |=> !out_valid);
endmodule

// File: tb/fbu_pixel_unpack_test.sv
`timescale 1ns/1ps
module fbu_pixel_unpack_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sol = 1'b0;
   logic [2:0]  depth = 3'd0;
   logic        bgr = 1'b0, beb = 1'b0, bep = 1'b0;
   logic [1:0]  fmux = 2'd0;
   logic [11:0] lpix = 12'd0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = 32'h0;
   logic        out_ready = 1'b0;

   logic [13:0] lb_a, lb_b;
   logic        rdy_a, rdy_b, val_a, val_b, ix_a, ix_b;
   logic [7:0]  idx_a, r_a, g_a, b_a, idx_b, r_b, g_b, b_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fbu_pixel_unpack #(.EXTENDED(1'b0), .PIX_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .sol(sol), .depth(depth), .bgr_order(bgr),
      .be_bytes(beb), .be_pixels(bep), .fmt_mux(fmux), .line_pixels(lpix),
      .line_bytes(lb_a), .in_valid(in_valid), .in_ready(rdy_a), .in_word(in_word),
      .out_valid(val_a), .out_ready(out_ready), .out_is_index(ix_a),
      .out_index(idx_a), .out_red(r_a), .out_green(g_a), .out_blue(b_a));

   fbu_pixel_unpack #(.EXTENDED(1'b1), .PIX_W(12)) uut_ext (
      .clk(clk), .rst_n(rst_n), .sol(sol), .depth(depth), .bgr_order(bgr),
      .be_bytes(beb), .be_pixels(bep), .fmt_mux(fmux), .line_pixels(lpix),
      .line_bytes(lb_b), .in_valid(in_valid), .in_ready(rdy_b), .in_word(in_word),
      .out_valid(val_b), .out_ready(out_ready), .out_is_index(ix_b),
      .out_index(idx_b), .out_red(r_b), .out_green(g_b), .out_blue(b_b));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int pix_w(input logic [2:0] d);
      case (d)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd5: return 32;
         default: return 16;
      endcase
   endfunction

   // Reference pixel from the requirement formulas
   function automatic logic [33:0] ref_pix(input bit ext, input logic [31:0] wd, input int k);
      int w, off, ppb, fmt;
      logic [31:0] v;
      logic [7:0] idx, r, g, b, f0, f1, f2;
      logic bl;
      w = pix_w(depth);
      if (beb) off = 32 - (k + 1) * w;
      else if (bep && w < 8) begin
         ppb = 8 / w;
         off = (k / ppb) * 8 + 8 - ((k % ppb) + 1) * w;
      end else off = k * w;
      v = wd >> off;
      if (depth < 3'd4) begin
         idx = v[7:0] & 8'((16'd1 << w) - 16'd1);
         return {1'b1, 1'b1, idx, 24'h0};
      end
      bl = bgr;
      if (depth == 3'd5) fmt = 3;
      else if (depth == 3'd7) fmt = 2;
      else if (depth == 3'd6) fmt = 1;
      else if (ext) fmt = 0;
      else if (fmux == 2'd1) fmt = 0;
      else if (fmux == 2'd3) begin fmt = 1; bl = 1'b1; end
      else fmt = 1;
      case (fmt)
         0: begin f0 = {v[4:0], 3'b0}; f1 = {v[9:5], 3'b0};  f2 = {v[14:10], 3'b0}; end
         1: begin f0 = {v[4:0], 3'b0}; f1 = {v[10:5], 2'b0}; f2 = {v[15:11], 3'b0}; end
         2: begin f0 = {v[3:0], 4'b0}; f1 = {v[7:4], 4'b0};  f2 = {v[11:8], 4'b0};  end
         default: begin f0 = v[7:0]; f1 = v[15:8]; f2 = v[23:16]; end
      endcase
      g = f1;
      r = bl ? f2 : f0;
      b = bl ? f0 : f2;
      return {1'b1, 1'b0, 8'h0, r, g, b};
   endfunction

   task automatic load(input logic [31:0] wd);
      @(negedge clk);
      in_valid  = 1'b1;
      in_word   = wd;
      out_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk("R10 out_valid after accept", {62'h0, val_a, val_b}, 64'h3);
   endtask

   task automatic pop(input string tag, input logic [31:0] wd, input int k);
      #1;
      chk({tag, " basic"}, 64'({val_a, ix_a, idx_a, r_a, g_a, b_a}), 64'(ref_pix(1'b0, wd, k)));
      chk({tag, " ext"},   64'({val_b, ix_b, idx_b, r_b, g_b, b_b}), 64'(ref_pix(1'b1, wd, k)));
      @(negedge clk);
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic run_word(input string tag, input logic [31:0] wd);
      load(wd);
      for (int k = 0; k < 32 / pix_w(depth); k++) pop(tag, wd, k);
      #1;
      chk({tag, " R10 empty after last"}, {63'h0, val_a}, 64'h0);
   endtask

   task automatic t_reset;
      #1;
      chk("R12 out_valid", {63'h0, val_a}, 64'h0);
      chk("R12 in_ready",  {63'h0, rdy_a}, 64'h1);
   endtask

   task automatic t_line_bytes;
      int e;
      for (int p = 0; p < 2; p++) begin
         lpix = (p == 0) ? 12'd640 : 12'd1000;
         for (int d = 0; d < 8; d++) begin
            depth = 3'(d);
            case (d)
               0: e = lpix / 8;
               1: e = lpix / 4;
               2: e = lpix / 2;
               3: e = lpix;
               5: e = lpix * 4;
               default: e = lpix * 2;
            endcase
            #1;
            chk("R2 line bytes", 64'(lb_a), 64'(e));
            chk("R2 line bytes ext", 64'(lb_b), 64'(e));
         end
      end
   endtask

   task automatic t_little_endian;
      beb = 0; bep = 0;
      for (int d = 0; d < 4; d++) begin
         depth = 3'(d);
         run_word("R3 R1 LE index", 32'hA5C3_1E69);
      end
   endtask

   task automatic t_big_bytes;
      beb = 1; bep = 0;
      depth = 3'd1; run_word("R4 BE bytes 2bpp", 32'h1B6C_93E4);
      depth = 3'd3; run_word("R4 BE bytes 8bpp", 32'h1122_3344);
      bgr = 1; depth = 3'd6; run_word("R4 BE bytes 565", 32'hF800_07E0);
      bep = 1; depth = 3'd2; run_word("R4 R5 both set", 32'h0123_4567);
      beb = 0; bep = 0; bgr = 0;
   endtask

   task automatic t_big_pixels;
      beb = 0; bep = 1;
      depth = 3'd0; run_word("R5 BE pix 1bpp", 32'h8001_40C2);
      depth = 3'd2; run_word("R5 BE pix 4bpp", 32'h7654_3210);
      depth = 3'd3; run_word("R5 BE pix 8bpp no effect", 32'hDEAD_BEEF);
      bep = 0;
   endtask

   task automatic t_direct;
      for (int bo = 0; bo < 2; bo++) begin
         bgr = bo[0];
         fmux = 2'd1;
         depth = 3'd4; run_word("R6 R7 5551", 32'hFC21_83E1);
         depth = 3'd5; run_word("R6 32bpp", 32'hEE12_3456);
         depth = 3'd7; run_word("R6 R7 12bpp", 32'hF9A5_0F3C);
      end
      bgr = 0;
   endtask

   task automatic t_mux;
      depth = 3'd4;
      for (int s = 0; s < 4; s++) begin
         fmux = 2'(s);
         bgr = 1'b0; run_word("R8 R9 mux bgr0", 32'hF81F_07E5);
         bgr = 1'b1; run_word("R8 R9 mux bgr1", 32'h83E0_7C1F);
      end
      depth = 3'd6; fmux = 2'd3; bgr = 1'b0;
      run_word("R8 R9 code6", 32'hF800_001F);
      fmux = 2'd0;
   endtask

   task automatic t_hold;
      depth = 3'd3;
      load(32'h4433_2211);
      repeat (3) @(negedge clk);
      #1;
      chk("R10 held index", {55'h0, val_a, idx_a}, {55'h0, 1'b1, 8'h11});
      chk("R10 in_ready low while full", {63'h0, rdy_a}, 64'h0);
      for (int k = 0; k < 3; k++) pop("R10 hold seq", 32'h4433_2211, k);
      out_ready = 1'b1;
      #1;
      chk("R10 in_ready on last pixel", {63'h0, rdy_a}, 64'h1);
      chk("R10 last pixel", 64'(idx_a), 64'h44);
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      #1;
      chk("R10 drained", {63'h0, val_a}, 64'h0);
   endtask

   task automatic t_sol;
      depth = 3'd3;
      load(32'h4433_2211);
      pop("R11 before sol", 32'h4433_2211, 0);
      sol = 1'b1;
      in_valid = 1'b1;
      in_word = 32'hFFFF_FFFF;
      #1;
      chk("R11 in_ready low in sol", {62'h0, rdy_a, rdy_b}, 64'h0);
      @(posedge clk);
      @(negedge clk);
      sol = 1'b0;
      in_valid = 1'b0;
      #1;
      chk("R11 flushed", {62'h0, val_a, val_b}, 64'h0);
      run_word("R11 new line", 32'h8877_6655);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_line_bytes;
      t_little_endian;
      t_big_bytes;
      t_big_pixels;
      t_direct;
      t_mux;
      t_hold;
      t_sol;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule